// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a wrapping 32-bit count of seconds. A prescaler divides the system clock by `CLK_HZ` to make a one-second tick, and the count advances on each tick. Software can overwrite the running count and program a match value. When the count becomes equal to the match value, a sticky alarm status is set. The status is gated by a one-bit mask to drive a level interrupt.

Access is through an APB-style slave port with 32-bit word-aligned registers. A small bus-phase state machine has three states: `S_IDLE` (no transfer), `S_SETUP` (a setup phase was seen in the previous cycle) and `S_ACCESS` (an access phase was seen in the previous cycle). The transitions are:
- `S_IDLE` to `S_SETUP` on select without enable.
- `S_SETUP` to `S_ACCESS` on select with enable. This cycle is the one where the transfer takes effect.
- `S_SETUP` to `S_IDLE` otherwise.
- `S_ACCESS` to `S_SETUP` on a back-to-back setup, and to `S_IDLE` otherwise.

The register offsets are:

| Offset | Register |
|---|---|
| 0x000 | running count (read only) |
| 0x004 | match value |
| 0x008 | load value |
| 0x00C | control |
| 0x010 | mask |
| 0x014 | raw status |
| 0x018 | gated status |
| 0x01C | clear |
| 0xFE0 to 0xFFC | identification bytes |

Top module: `sec_alarm_ctr`

## Requirements
- R1: The count advances by exactly one every `CLK_HZ` clock cycles. After a load that takes effect at edge E, the count still holds the loaded value after edge E+CLK_HZ-1 and has advanced by one after edge E+CLK_HZ.
- R2: A write to offset 0x008 replaces the count at the edge where the write takes effect. Offset 0x000 reads the current count, and offset 0x008 reads the last value written there.
- R3: The count wraps from 0xFFFFFFFF to 0. A match value of 0 then raises the alarm at that wrap.
- R4: Raw status (offset 0x014, bit 0) is set on the edge where a tick brings the count equal to the match value. It is also set on the edge where a write to the match (0x004) or load (0x008) register makes the two equal. It stays set until cleared.
- R5: Only bit 0 of a mask write (0x010) is stored. The output `irq` equals raw status AND mask, and offset 0x018 reads the same bit.
- R6: Any write to offset 0x01C clears raw status, whatever the data. If the alarm condition occurs in the same cycle as the clear, the status stays set.
- R7: Offset 0x00C always reads 1, and writes to it change nothing.
- R8: Offsets 0xFE0, 0xFE4, through 0xFFC read, in that order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Writes to offsets 0x000, 0x014 and 0x018 have no effect. A read of 0x01C returns 0.
- R10: A read of an unmapped or non-word-aligned offset returns 0, with `pslverr` high in that access cycle only. Mapped reads return `pslverr` low. Writes to unmapped offsets are ignored.
- R11: After reset the count, match value, loaded value, mask and status are 0, and `irq` is low.
- R12: A transfer takes effect only in an access phase that directly follows a setup phase. An enable with no preceding setup does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data, valid in the access cycle |
| pslverr | output | 1 | Error response for an unmapped read |
| irq | output | 1 | Level interrupt: status AND mask |

## Verification
A wrong prescaler phase shows up as the count read at 0x000 being one second early or late relative to a load. It is caught within `CLK_HZ` cycles of the load, because a load restarts the phase. A wrong status or mask bit shows on `irq` on the cycle right after the edge where a write or tick takes effect, before any read-back. A wrong decode returns the wrong word, or a wrong error flag, in the access cycle of that read.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int unsigned AW = 12;

    localparam logic [AW-1:0] OFS_COUNT = 12'h000;
    localparam logic [AW-1:0] OFS_MATCH = 12'h004;
    localparam logic [AW-1:0] OFS_LOAD  = 12'h008;
    localparam logic [AW-1:0] OFS_CTRL  = 12'h00C;
    localparam logic [AW-1:0] OFS_MASK  = 12'h010;
    localparam logic [AW-1:0] OFS_RAW   = 12'h014;
    localparam logic [AW-1:0] OFS_GATED = 12'h018;
    localparam logic [AW-1:0] OFS_CLEAR = 12'h01C;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETUP  = 2'd1,
        S_ACCESS = 2'd2
    } bus_st_t;

    typedef struct packed {
        logic load;
        logic match;
        logic mask;
        logic clear;
    } wr_stb_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sac_prescaler.sv
module sac_prescaler #(
    parameter int unsigned CLK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);

endmodule

// File: rtl/sac_timekeep.sv
module sac_timekeep
    import sac_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  wr_stb_t       stb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] match_q,
    output logic [DW-1:0] loaded_q,
    output logic          mask_q,
    output logic          status_q
);
    logic [DW-1:0] count_d;
    logic [DW-1:0] match_d;
    logic          step;
    logic          hit;

    always_comb begin
        if (stb.load) begin
            count_d = wdata;
        end else if (tick) begin
            count_d = count_q + 1'b1;
        end else begin
            count_d = count_q;
        end
        match_d = stb.match ? wdata : match_q;
        step    = stb.load | stb.match | tick;
        hit     = step && (count_d == match_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            match_q  <= '0;
            loaded_q <= '0;
            mask_q   <= 1'b0;
            status_q <= 1'b0;
        end else begin
            count_q <= count_d;
            match_q <= match_d;
            if (stb.load) begin
                loaded_q <= wdata;
            end
            if (stb.mask) begin
                mask_q <= wdata[0];
            end
            if (hit) begin
                status_q <= 1'b1;
            end else if (stb.clear) begin
                status_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sac_bus_fsm.sv
module sac_bus_fsm
    import sac_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] count_q,
    input  logic [DW-1:0] match_q,
    input  logic [DW-1:0] loaded_q,
    input  logic          mask_q,
    input  logic          status_q,
    output wr_stb_t       stb,
    output logic [DW-1:0] prdata,
    output logic          pslverr
);
    bus_st_t st_q;
    bus_st_t st_d;
    logic    acc;
    logic    in_id;
    logic [DW-1:0] rval;
    logic    mapped;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = S_IDLE;
        unique case (st_q)
            S_IDLE:   st_d = (psel && !penable) ? S_SETUP : S_IDLE;
            S_SETUP:  st_d = (psel && penable) ? S_ACCESS : S_IDLE;
            S_ACCESS: st_d = (psel && !penable) ? S_SETUP : S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    always_comb begin
        acc    = (st_q == S_SETUP) && psel && penable;
        in_id  = (paddr[AW-1:5] == 7'h7F) && (paddr[1:0] == 2'b00);
        mapped = 1'b1;
        rval   = '0;
        if (in_id) begin
            rval = DW'(id_byte(paddr[4:2]));
        end else begin
            unique case (paddr)
                OFS_COUNT: rval = count_q;
                OFS_MATCH: rval = match_q;
                OFS_LOAD:  rval = loaded_q;
                OFS_CTRL:  rval = DW'(1);
                OFS_MASK:  rval = DW'(mask_q);
                OFS_RAW:   rval = DW'(status_q);
                OFS_GATED: rval = DW'(status_q & mask_q);
                OFS_CLEAR: rval = '0;
                default:   mapped = 1'b0;
            endcase
        end
        stb.load  = acc && pwrite && (paddr == OFS_LOAD);
        stb.match = acc && pwrite && (paddr == OFS_MATCH);
        stb.mask  = acc && pwrite && (paddr == OFS_MASK);
        stb.clear = acc && pwrite && (paddr == OFS_CLEAR);
        prdata    = (acc && !pwrite) ? rval : '0;
        pslverr   = acc && !pwrite && !mapped;
    end

endmodule

// File: rtl/sec_alarm_ctr.sv
module sec_alarm_ctr
    import sac_pkg::*;
#(
    parameter int unsigned CLK_HZ = 1_000_000,
    parameter int unsigned DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [11:0]   paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pslverr,
    output logic          irq
);
    wr_stb_t       stb;
    logic          tick;
    logic [DW-1:0] count_q;
    logic [DW-1:0] match_q;
    logic [DW-1:0] loaded_q;
    logic          mask_q;
    logic          status_q;

    sac_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (stb.load),
        .tick    (tick)
    );

    sac_timekeep #(.DW(DW)) u_tk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .stb      (stb),
        .wdata    (pwdata),
        .count_q  (count_q),
        .match_q  (match_q),
        .loaded_q (loaded_q),
        .mask_q   (mask_q),
        .status_q (status_q)
    );

    sac_bus_fsm #(.DW(DW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .count_q  (count_q),
        .match_q  (match_q),
        .loaded_q (loaded_q),
        .mask_q   (mask_q),
        .status_q (status_q),
        .stb      (stb),
        .prdata   (prdata),
        .pslverr  (pslverr)
    );

    assign irq = status_q & mask_q;

endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic          pslverr,
    input logic          irq,
    input logic          tick,
    input logic          wr_load,
    input logic          wr_clear,
    input logic [DW-1:0] count_q,
    input logic          mask_q,
    input logic          status_q
);
    a_r10_err_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable && !pwrite));

    a_r4_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !wr_clear) |=> status_q);

    a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mask_q);

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_load && count_q == {DW{1'b1}}) |=> (count_q == '0));

    a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_load) |=> $stable(count_q));

    a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

bind sec_alarm_ctr sac_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .pslverr  (pslverr),
    .irq      (irq),
    .tick     (tick),
    .wr_load  (stb.load),
    .wr_clear (stb.clear),
    .count_q  (count_q),
    .mask_q   (mask_q),
    .status_q (status_q)
);

// File: tb/sec_alarm_ctr_tb.sv
module sec_alarm_ctr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HZ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pslverr;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    sec_alarm_ctr #(.CLK_HZ(HZ), .DW(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pslverr(pslverr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        e = pslverr;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic e;
        rd(a, d, e);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        check("R11 irq", {31'd0, irq}, 32'd0);
        rd_chk("R11 count", 12'h000, 32'd0);
        rd_chk("R11 match", 12'h004, 32'd0);
        rd_chk("R11 loaded", 12'h008, 32'd0);
        rd_chk("R11 mask", 12'h010, 32'd0);
        rd_chk("R11 raw", 12'h014, 32'd0);
    endtask

    task automatic t_load_read;
        wr(12'h008, 32'h1234_5678);
        rd_chk("R2 count after load", 12'h000, 32'h1234_5678);
        rd_chk("R2 load readback", 12'h008, 32'h1234_5678);
    endtask

    task automatic t_prescaler;
        wr(12'h008, 32'd500);
        idle(5);
        rd_chk("R1 before terminal", 12'h000, 32'd500);
        wr(12'h008, 32'd500);
        idle(6);
        rd_chk("R1 at terminal", 12'h000, 32'd501);
    endtask

    task automatic t_immediate;
        wr(12'h01C, 32'h0);
        wr(12'h010, 32'h0);
        wr(12'h008, 32'd100);
        wr(12'h004, 32'd100);
        rd_chk("R4 match write sets raw", 12'h014, 32'd1);
        check("R5 irq masked off", {31'd0, irq}, 32'd0);
        rd_chk("R5 gated off", 12'h018, 32'd0);
        wr(12'h010, 32'h1);
        check("R5 irq on", {31'd0, irq}, 32'd1);
        rd_chk("R5 gated on", 12'h018, 32'd1);
        wr(12'h01C, 32'hFFFF_FFFE);
        check("R6 clear any data", {31'd0, irq}, 32'd0);
        wr(12'h004, 32'd200);
        wr(12'h008, 32'd200);
        check("R4 load write sets irq at once", {31'd0, irq}, 32'd1);
        wr(12'h01C, 32'h0);
        check("R6 clear zero data", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_tick_match;
        wr(12'h008, 32'd299);
        wr(12'h004, 32'd300);
        idle(4);
        check("R4 not yet", {31'd0, irq}, 32'd0);
        idle(1);
        check("R4 tick match", {31'd0, irq}, 32'd1);
        idle(20);
        check("R4 sticky", {31'd0, irq}, 32'd1);
        wr(12'h01C, 32'h0);
    endtask

    task automatic t_wrap;
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h004, 32'h0);
        idle(4);
        check("R3 before wrap", {31'd0, irq}, 32'd0);
        idle(1);
        check("R3 wrap match", {31'd0, irq}, 32'd1);
        rd_chk("R3 count wrapped", 12'h000, 32'd0);
        wr(12'h01C, 32'h0);
    endtask

    task automatic t_priority;
        wr(12'h01C, 32'h0);
        wr(12'h004, 32'd41);
        wr(12'h008, 32'd40);
        idle(5);
        wr(12'h01C, 32'h1);
        check("R6 set wins over clear", {31'd0, irq}, 32'd1);
        wr(12'h01C, 32'h1);
        check("R6 later clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_ignored;
        rd_chk("R7 ctrl reads one", 12'h00C, 32'd1);
        wr(12'h00C, 32'h0);
        rd_chk("R7 ctrl after write", 12'h00C, 32'd1);
        wr(12'h008, 32'd777);
        wr(12'h000, 32'd5);
        rd_chk("R9 count write ignored", 12'h000, 32'd777);
        wr(12'h014, 32'h1);
        rd_chk("R9 raw write ignored", 12'h014, 32'd0);
        wr(12'h018, 32'h1);
        rd_chk("R9 gated write ignored", 12'h014, 32'd0);
        rd_chk("R9 clear reads zero", 12'h01C, 32'd0);
        wr(12'h010, 32'hFFFF_FFFE);
        rd_chk("R5 mask bit0 only low", 12'h010, 32'd0);
        wr(12'h010, 32'h3);
        rd_chk("R5 mask bit0 only high", 12'h010, 32'd1);
    endtask

    task automatic t_id;
        logic [7:0] exp_id [8];
        exp_id = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            rd_chk("R8 id byte", 12'hFE0 + 12'(i * 4), {24'd0, exp_id[i]});
        end
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        logic e;
        rd(12'h020, d, e);
        check("R10 unmapped data", d, 32'd0);
        check("R10 unmapped err", {31'd0, e}, 32'd1);
        check("R10 err one cycle", {31'd0, pslverr}, 32'd0);
        rd(12'h006, d, e);
        check("R10 misaligned err", {31'd0, e}, 32'd1);
        rd(12'h004, d, e);
        check("R10 mapped no err", {31'd0, e}, 32'd0);
        wr(12'h004, 32'h10);
        wr(12'h024, 32'h99);
        rd_chk("R10 unmapped write ignored", 12'h004, 32'h10);
    endtask

    task automatic t_no_setup;
        wr(12'h004, 32'h10);
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 12'h004; pwdata = 32'h55;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        rd_chk("R12 enable without setup ignored", 12'h004, 32'h10);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_load_read();
        t_prescaler();
        t_immediate();
        t_tick_match();
        t_wrap();
        t_priority();
        t_ignored();
        t_id();
        t_unmapped();
        t_no_setup();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule